// File: doc/BRIEF.md
# Instruction Page Escape Stack

This unit tracks which alternate opcode page a compact instruction decoder is using. A page-select command gives a 3-bit subpage number and a 4-bit activation length. The unit pushes this selection onto a stack of up to four entries. The top entry is the live page. Ordinary retired instructions count the top entry down, and an entry that reaches zero leaves the stack by itself. A length of all ones pins the entry so that it never counts down. A taken branch drops every entry that has a limited length. A pop command uncovers the entry below the top. A return-to-base command empties the whole stack.

All state lives in one 32-bit control word. Software can read the word and write it back to save and restore the page context across calls or context switches. The word holds four 7-bit entries and a 3-bit depth. Entry k sits at bits [7k+6:7k], with the subpage in the upper 3 bits of the entry and the length in the lower 4 bits. The depth sits at bits [30:28], and bit 31 always reads zero.

None of the pins carries a data stream. Commands are single-cycle decoded pulses, and the register port is a plain write strobe with an always-valid read value. There is no valid/ready handshake and no back-pressure.

Top module: `page_esc_stack`

## Requirements
- R1: After reset the register reads zero, default_o is high and page_o is zero.
- R2: A select command at depth d below four writes {subpage, length} into entry d and makes the depth d+1. page_o then shows the new subpage and default_o goes low.
- R3: A select command at depth four replaces entry 3 and leaves the depth at four.
- R4: When retire_i is high and no select, pop, return-to-base or branch is present, a top length from 1 to 14 goes down by one. If the length was 1, the top entry is cleared to zero and the depth goes down by one.
- R5: A top entry with length 15 is not changed by retired instructions.
- R6: A taken branch removes every entry whose length is not 15. The remaining entries move down to the lowest slots in their original order, the slots above the new depth read zero, and the depth becomes the number of remaining entries.
- R7: When a branch and a select arrive in the same cycle, the branch filtering of R6 happens first and the new selection is then pushed onto the filtered stack.
- R8: A pop command at depth d greater than zero clears entry d-1 and sets the depth to d-1. A pop at depth zero changes nothing.
- R9: A return-to-base command sets the whole register to zero.
- R10: A register write takes priority over every command in the same cycle. It loads bits [27:0] as written and sets the depth to the smaller of the written value and four. Bit 31 reads zero.
- R11: default_o is high exactly when the depth is zero, and page_o is zero in that case. Otherwise page_o is the subpage of entry depth-1.
- R12: Among commands in the same cycle, return-to-base wins over pop, and pop wins over select. Any of these commands stops retire_i from counting down in that cycle.
- R13: A top entry with length 0 is not counted down and stays until it is popped, cleared by a branch, or cleared by return-to-base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| sel_i | input | 1 | Page-select command |
| sel_page_i | input | 3 | Subpage number of the select command |
| sel_len_i | input | 4 | Activation length of the select command; 15 means permanent |
| pop_i | input | 1 | Pop-one command |
| base_i | input | 1 | Return-to-base command |
| branch_i | input | 1 | Taken branch |
| csr_we_i | input | 1 | Control register write strobe |
| csr_wdata_i | input | 32 | Control register write value |
| page_o | output | 3 | Active subpage |
| default_o | output | 1 | Base instruction set active |
| csr_rdata_o | output | 32 | Packed control register value |

## Verification
The assertions assume that the command inputs are single-cycle pulses sampled on the clock edge and that they are held low during reset. The countdown and branch assertions also assume that the state was reached through the unit's own rules or through a write with an in-range depth. The bench changes its inputs only on falling edges and returns every strobe to zero after each step. It uses register writes, including writes with out-of-range depths, to place the stack in chosen states before it sweeps subpages, lengths and command combinations.

// File: rtl/page_esc_pkg.sv
package page_esc_pkg;
  localparam int SUB_W   = 3;
  localparam int LEN_W   = 4;
  localparam int STACK_N = 4;
  localparam int ENT_W   = SUB_W + LEN_W;
  localparam int DEP_W   = $clog2(STACK_N + 1);
  localparam int REG_W   = 32;
  localparam int DEP_LSB = ENT_W * STACK_N;
  localparam logic [LEN_W-1:0] LEN_PERM = '1;

  typedef struct packed {
    logic [SUB_W-1:0] page;
    logic [LEN_W-1:0] len;
  } pes_entry_t;

  typedef pes_entry_t [STACK_N-1:0] pes_stack_t;
endpackage

// File: rtl/pes_branch_filter.sv
module pes_branch_filter
  import page_esc_pkg::*;
(
  input  logic             branch_i,
  input  pes_stack_t       stk_i,
  input  logic [DEP_W-1:0] dep_i,
  output pes_stack_t       stk_o,
  output logic [DEP_W-1:0] dep_o
);
  logic [DEP_W-1:0] keep;

  always_comb begin
    stk_o = stk_i;
    dep_o = dep_i;
    keep  = '0;
    if (branch_i) begin
      stk_o = '0;
      for (int i = 0; i < STACK_N; i++) begin
        if (DEP_W'(i) < dep_i && stk_i[i].len == LEN_PERM) begin
          stk_o[keep[DEP_W-2:0]] = stk_i[i];
          keep = keep + 1'b1;
        end
      end
      dep_o = keep;
    end
  end
endmodule

// File: rtl/pes_cmd_update.sv
module pes_cmd_update
  import page_esc_pkg::*;
(
  input  pes_stack_t       stk_i,
  input  logic [DEP_W-1:0] dep_i,
  input  logic             retire_i,
  input  logic             sel_i,
  input  pes_entry_t       sel_ent_i,
  input  logic             pop_i,
  input  logic             base_i,
  output pes_stack_t       stk_o,
  output logic [DEP_W-1:0] dep_o
);
  localparam logic [DEP_W-1:0] FULL = DEP_W'(STACK_N);
  logic [DEP_W-2:0] top;

  always_comb begin
    top   = (dep_i == '0) ? '0 : DEP_W'(dep_i - 1'b1);
    stk_o = stk_i;
    dep_o = dep_i;
    if (base_i) begin
      stk_o = '0;
      dep_o = '0;
    end else if (pop_i) begin
      if (dep_i != '0) begin
        stk_o[top] = '0;
        dep_o = dep_i - 1'b1;
      end
    end else if (sel_i) begin
      if (dep_i >= FULL) begin
        stk_o[STACK_N-1] = sel_ent_i;
      end else begin
        stk_o[dep_i[DEP_W-2:0]] = sel_ent_i;
        dep_o = dep_i + 1'b1;
      end
    end else if (retire_i && dep_i != '0) begin
      if (stk_i[top].len != LEN_PERM && stk_i[top].len != '0) begin
        if (stk_i[top].len == LEN_W'(1)) begin
          stk_o[top] = '0;
          dep_o = dep_i - 1'b1;
        end else begin
          stk_o[top].len = stk_i[top].len - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/page_esc_stack.sv
module page_esc_stack
  import page_esc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             sel_i,
  input  logic [SUB_W-1:0] sel_page_i,
  input  logic [LEN_W-1:0] sel_len_i,
  input  logic             pop_i,
  input  logic             base_i,
  input  logic             branch_i,
  input  logic             csr_we_i,
  input  logic [REG_W-1:0] csr_wdata_i,
  output logic [SUB_W-1:0] page_o,
  output logic             default_o,
  output logic [REG_W-1:0] csr_rdata_o
);
  localparam logic [DEP_W-1:0] FULL = DEP_W'(STACK_N);

  pes_stack_t       stk_q, stk_f, stk_n;
  logic [DEP_W-1:0] dep_q, dep_f, dep_n, wr_dep;
  pes_entry_t       sel_ent, top_ent;

  assign sel_ent = '{page: sel_page_i, len: sel_len_i};

  pes_branch_filter u_filter (
    .branch_i (branch_i),
    .stk_i    (stk_q),
    .dep_i    (dep_q),
    .stk_o    (stk_f),
    .dep_o    (dep_f)
  );

  pes_cmd_update u_update (
    .stk_i     (stk_f),
    .dep_i     (dep_f),
    .retire_i  (retire_i),
    .sel_i     (sel_i),
    .sel_ent_i (sel_ent),
    .pop_i     (pop_i),
    .base_i    (base_i),
    .stk_o     (stk_n),
    .dep_o     (dep_n)
  );

  assign wr_dep = (csr_wdata_i[DEP_LSB +: DEP_W] > FULL) ? FULL
                                                         : csr_wdata_i[DEP_LSB +: DEP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
      dep_q <= '0;
    end else if (csr_we_i) begin
      stk_q <= csr_wdata_i[DEP_LSB-1:0];
      dep_q <= wr_dep;
    end else begin
      stk_q <= stk_n;
      dep_q <= dep_n;
    end
  end

  assign top_ent     = (dep_q == '0) ? '0 : stk_q[DEP_W'(dep_q - 1'b1)];
  assign default_o   = (dep_q == '0);
  assign page_o      = top_ent.page;
  assign csr_rdata_o = REG_W'({dep_q, stk_q});

  logic no_cmd;
  assign no_cmd = !csr_we_i && !sel_i && !pop_i && !base_i && !branch_i;

  // R11
  depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dep_q <= FULL);

  // R11
  base_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    default_o |-> page_o == '0);

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_wdata_i[DEP_LSB +: DEP_W] <= FULL)
      |=> csr_rdata_o == {1'b0, $past(csr_wdata_i[REG_W-2:0])});

  // R9
  base_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_i && !csr_we_i) |=> default_o && csr_rdata_o == '0);

  // R2
  sel_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !csr_we_i && !pop_i && !base_i)
      |=> !default_o && page_o == $past(sel_page_i));

  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && no_cmd && !default_o && top_ent.len > LEN_W'(1)
       && top_ent.len != LEN_PERM)
      |=> $stable(dep_q) && top_ent.len == $past(top_ent.len) - 1'b1);

  // R6
  branch_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_i && !csr_we_i && !sel_i && !pop_i && !base_i && !default_o
       && top_ent.len == LEN_PERM)
      |=> !default_o && page_o == $past(page_o));
endmodule

// File: tb/test_page_esc_stack.sv
module test_page_esc_stack;
  logic clk = 0, rst_n = 0;
  logic retire_i = 0, sel_i = 0, pop_i = 0, base_i = 0, branch_i = 0, csr_we_i = 0;
  logic [2:0] sel_page_i = 0;
  logic [3:0] sel_len_i = 0;
  logic [31:0] csr_wdata_i = 0;
  logic [2:0] page_o;
  logic default_o;
  logic [31:0] csr_rdata_o;
  int checks = 0, errors = 0;
  logic [31:0] mreg = 0;

  always #10 clk = ~clk;

  page_esc_stack i_page_esc_stack (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .sel_i(sel_i),
    .sel_page_i(sel_page_i), .sel_len_i(sel_len_i), .pop_i(pop_i),
    .base_i(base_i), .branch_i(branch_i), .csr_we_i(csr_we_i),
    .csr_wdata_i(csr_wdata_i), .page_o(page_o), .default_o(default_o),
    .csr_rdata_o(csr_rdata_o));

  function automatic logic [31:0] pack(logic [6:0] e [4], int d);
    logic [31:0] r = 0;
    for (int k = 0; k < 4; k++) r[7*k +: 7] = (k < d) ? e[k] : 7'd0;
    r[30:28] = 3'(d);
    return r;
  endfunction

  // Reference: expected next register word from the requirement text
  function automatic logic [31:0] model(logic [31:0] r, logic we, logic [31:0] wd,
      logic ret, logic sel, logic [2:0] sp, logic [3:0] sl, logic pop, logic bs, logic br);
    logic [6:0] e [4];
    logic [6:0] f [4];
    int d, n;
    if (we) begin
      r = {1'b0, (wd[30:28] > 3'd4) ? 3'd4 : wd[30:28], wd[27:0]};
      return r;
    end
    d = int'(r[30:28]);
    for (int k = 0; k < 4; k++) e[k] = r[7*k +: 7];
    if (br) begin
      n = 0;
      for (int k = 0; k < 4; k++) f[k] = 0;
      for (int k = 0; k < d; k++) if (e[k][3:0] == 4'hF) begin f[n] = e[k]; n++; end
      e = f; d = n;
      r = pack(e, d);
    end
    if (bs) return 32'd0;
    if (pop) begin
      if (d > 0) d--;
      return (d == int'(r[30:28])) ? r : pack(e, d);
    end
    if (sel) begin
      if (d == 4) e[3] = {sp, sl};
      else begin e[d] = {sp, sl}; d++; end
      return pack(e, d);
    end
    if (ret && d > 0 && e[d-1][3:0] != 4'hF && e[d-1][3:0] != 0) begin
      if (e[d-1][3:0] == 1) d--;
      else e[d-1][3:0] = e[d-1][3:0] - 1;
      return pack(e, d);
    end
    return r;
  endfunction

  task automatic verify(string tag);
    logic [2:0] ep;
    int d = int'(mreg[30:28]);
    ep = (d == 0) ? 3'd0 : mreg[7*(d-1)+4 +: 3];
    checks++;
    if (csr_rdata_o !== mreg || page_o !== ep || default_o !== (d == 0)) begin
      errors++;
      $display("FAIL %s reg %h page %0d dflt %0d exp reg %h page %0d dflt %0d",
               tag, csr_rdata_o, page_o, default_o, mreg, ep, d == 0);
    end
  endtask

  task automatic step(string tag, logic ret, logic sel, logic [2:0] sp, logic [3:0] sl,
                      logic pop, logic bs, logic br, logic we, logic [31:0] wd);
    @(negedge clk);
    retire_i = ret; sel_i = sel; sel_page_i = sp; sel_len_i = sl; pop_i = pop;
    base_i = bs; branch_i = br; csr_we_i = we; csr_wdata_i = wd;
    mreg = model(mreg, we, wd, ret, sel, sp, sl, pop, bs, br);
    @(negedge clk);
    retire_i = 0; sel_i = 0; pop_i = 0; base_i = 0; branch_i = 0; csr_we_i = 0;
    verify(tag);
  endtask

  task automatic push(string tag, logic [2:0] p, logic [3:0] l);
    step(tag, 1'b1, 1'b1, p, l, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
  endtask
  task automatic clear(string tag);
    step(tag, 1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
  endtask
  task automatic retire(string tag);
    step(tag, 1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
  endtask
  task automatic wr(string tag, logic [31:0] v);
    step(tag, 1'b0, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, v);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    verify("R1");

    // R2 R3: subpage sweep through push and full-stack replace
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 6; k++) push(k < 4 ? "R2" : "R3", 3'(p + k), 4'(k + 9));
      clear("R9");
    end

    // R4 R13: every length counted down to its expiry
    for (int l = 0; l < 15; l++) begin
      push("R2", 3'd5, 4'hF);
      push("R2", 3'(l), 4'(l));
      for (int r = 0; r <= l + 1; r++) retire(l == 0 ? "R13" : "R4");
      clear("R9");
    end

    // R5
    push("R5", 3'd3, 4'hF);
    for (int r = 0; r < 4; r++) retire("R5");

    // R6 R7
    wr("R10", {1'b0, 3'd4, 7'h4F, 7'h13, 7'h2F, 7'h55});
    step("R6", 1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
    wr("R10", {1'b0, 3'd3, 7'h00, 7'h32, 7'h6F, 7'h21});
    step("R7", 1'b1, 1'b1, 3'd7, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
    step("R6", 1'b1, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);

    // R8 including pop at depth zero
    wr("R10", {1'b0, 3'd3, 7'h00, 7'h3A, 7'h6F, 7'h21});
    for (int k = 0; k < 5; k++)
      step("R8", 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);

    // R12: every command combination with retire from a fixed state
    for (int c = 0; c < 16; c++) begin
      wr("R10", {1'b0, 3'd2, 14'd0, 7'h36, 7'h1F});
      step("R12", c[3], c[0], 3'd6, 4'd4, c[1], c[2], 1'b0, 1'b0, 32'd0);
    end

    // R10: write beats all commands; depth clamp; bit 31
    for (int d = 0; d < 8; d++)
      step("R10", 1'b1, 1'b1, 3'd1, 4'd1, 1'b1, 1'b1, 1'b1, 1'b1,
           {1'b1, 3'(d), 28'h9ABCDEF ^ 28'(d * 28'h1111111)});
    wr("R10", {1'b0, 3'd3, 7'h00, 7'h48, 7'h3F, 7'h77});
    saved = csr_rdata_o;
    clear("R9");
    wr("R10", saved);

    // R11: page output tracks top across depths
    clear("R9");
    for (int k = 0; k < 4; k++) push("R11", 3'(7 - k), 4'hF);
    for (int k = 0; k < 4; k++)
      step("R11", 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule